// File: doc/BRIEF.md
# Host Bridge Configuration Space with Shadow Segment Control

This block holds the byte-wide configuration space of a host bridge. Software reaches it through a simple strobe interface that carries a function number, an 8-bit offset and a data byte. Only function 0 exists. Each offset has its own write rule: some bytes are read-only identity information, some are masked or forced as they are stored, and the rest store the written byte unchanged.

Two of the writable bytes control how the four 16 KB shadow segments of the upper BIOS window (starting at 0xE0000 and spaced 0x4000 apart) are handled. A nibble of per-segment enables, together with a two-bit mode field that all segments share, gives each segment a read-internal flag and a write-internal flag. Memory steering logic elsewhere on the chip uses these flags. A warm system reset pulse clears the segment enables and keeps the low nibble of their byte. The active-low asynchronous reset reloads the whole default image.

Top module: `host_cfg_shadow`

## Requirements
- R1: An access whose function number is not 0 changes no byte on a write, and returns 0xFF on a strobed read.
- R2: Read data is combinational from the stored bytes in the cycle the read strobe is high. With the strobe low the read bus is 0x00.
- R3: After reset the space reads 0x39,0x10,0x06,0x04 at offsets 0x00–0x03, 0x07 at 0x04, 0x00 at 0x05, 0x80 at 0x06, 0x02 at 0x07, 0x00,0x00,0x06 at 0x09–0x0B, 0xBC,0xFB,0xAD,0xFE at 0x50–0x53, and 0x00 at every other offset.
- R4: Writes to offsets 0x00–0x03, 0x08–0x0C, 0x0E and 0x10–0x4E are discarded.
- R5: A write to 0x04 stores (data AND 0x42) OR 0x04. A write to 0x05 stores only bit 0 of the data.
- R6: A write to 0x06 stores 0x00 and a write to 0x07 stores 0x02, whatever the data.
- R7: Writes to 0x0D, 0x0F and 0x4F–0xFF store the data byte unchanged.
- R8: Segment d is enabled by bit 4+d of offset 0x54. Bits 6:5 of offset 0x53 set the attributes of every enabled segment: 00 gives read external and write internal, 01 gives both external, 10 gives both internal, 11 gives read internal and write external. A disabled segment is external for both. A flag of 1 means internal.
- R9: The segment flags are registered. They follow a write to 0x53 or 0x54 on the second rising edge after the write strobe is presented: the first edge stores the byte and the second updates the flags.
- R10: A cycle with the system reset pulse high replaces offset 0x54 with its old value AND 0x0F, and it discards any configuration write presented in that cycle.
- R11: Asserting the active-low reset restores the default image at once, without waiting for a clock edge, and drives both segment flag vectors to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the default image |
| sys_rst | input | 1 | Warm system reset pulse, turns all shadow segments off |
| cfg_func | input | FUNC_W | Function number of the access |
| cfg_addr | input | 8 | Byte offset of the access |
| cfg_wdata | input | 8 | Write data |
| cfg_wr | input | 1 | Write strobe, one cycle per byte |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Read data, valid while cfg_rd is high |
| shd_rd_int | output | SEG_COUNT | Per-segment read-internal flag |
| shd_wr_int | output | SEG_COUNT | Per-segment write-internal flag |

## Verification
The bench builds the block with its default values: a 3-bit function number and four shadow segments. With this small configuration it can write and read back every one of the 256 offsets under every write rule, send a write with each nonzero function number, and step through all 64 combinations of mode field and enable nibble. It also checks the two-edge latency of the flags, a warm reset pulse that collides with a write, and an asynchronous reset in the middle of the run.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

  localparam int unsigned CFG_BYTES = 256;
  localparam int unsigned OFS_W     = 8;

  // Offsets whose fields are decoded by the shadow logic.
  localparam logic [7:0] OFS_MODE = 8'h53;
  localparam logic [7:0] OFS_SEGEN = 8'h54;
  localparam int unsigned MODE_LSB = 5;
  localparam int unsigned SEGEN_LSB = 4;

  // Masked / forced offsets.
  localparam logic [7:0] OFS_CMD_LO = 8'h04;
  localparam logic [7:0] OFS_CMD_HI = 8'h05;
  localparam logic [7:0] OFS_STS_LO = 8'h06;
  localparam logic [7:0] OFS_STS_HI = 8'h07;

  typedef enum logic [1:0] {
    SHD_RX_WI = 2'b00,
    SHD_RX_WX = 2'b01,
    SHD_RI_WI = 2'b10,
    SHD_RI_WX = 2'b11
  } shd_mode_e;

  // Default image of the space after the asynchronous reset.
  function automatic logic [7:0] cfg_default(input int unsigned ofs);
    logic [7:0] v;
    case (ofs)
      'h00: v = 8'h39;
      'h01: v = 8'h10;
      'h02: v = 8'h06;
      'h03: v = 8'h04;
      'h04: v = 8'h07;
      'h06: v = 8'h80;
      'h07: v = 8'h02;
      'h0B: v = 8'h06;
      'h50: v = 8'hBC;
      'h51: v = 8'hFB;
      'h52: v = 8'hAD;
      'h53: v = 8'hFE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // Offsets that never accept a write.
  function automatic logic cfg_read_only(input logic [7:0] ofs);
    logic ro;
    ro = 1'b0;
    if (ofs <= 8'h03) ro = 1'b1;
    if ((ofs >= 8'h08) && (ofs <= 8'h0C)) ro = 1'b1;
    if (ofs == 8'h0E) ro = 1'b1;
    if ((ofs >= 8'h10) && (ofs <= 8'h4E)) ro = 1'b1;
    return ro;
  endfunction

endpackage

// File: rtl/hbcfg_wfilter.sv
module hbcfg_wfilter
  import hbcfg_pkg::*;
#(
  parameter int unsigned FUNC_W = 3
) (
  input  logic [FUNC_W-1:0] cfg_func,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              cfg_wr,
  output logic              wr_ok,
  output logic [7:0]        wr_byte
);

  logic func_zero;

  assign func_zero = (cfg_func == '0);

  always_comb begin
    wr_ok = cfg_wr & func_zero & ~cfg_read_only(cfg_addr);
  end

  always_comb begin
    unique case (cfg_addr)
      OFS_CMD_LO: wr_byte = (cfg_wdata & 8'h42) | 8'h04;
      OFS_CMD_HI: wr_byte = cfg_wdata & 8'h01;
      OFS_STS_LO: wr_byte = 8'h00;
      OFS_STS_HI: wr_byte = 8'h02;
      default:    wr_byte = cfg_wdata;
    endcase
  end

endmodule

// File: rtl/hbcfg_regfile.sv
module hbcfg_regfile
  import hbcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       wr_ok,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_byte,
  output logic [7:0] cfg_q [CFG_BYTES]
);

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    localparam logic [7:0] RST_VAL = cfg_default(i);
    logic       ld;
    logic [7:0] d;
    logic [7:0] q_r;
    logic       hit;

    assign hit = wr_ok & (wr_addr == 8'(i));

    if (i == int'(OFS_SEGEN)) begin : g_segen
      // warm reset wins over a write in the same cycle
      always_comb begin
        ld = sys_rst | hit;
        d  = sys_rst ? (q_r & 8'h0F) : wr_byte;
      end
    end else begin : g_plain
      always_comb begin
        ld = ~sys_rst & hit;
        d  = wr_byte;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= RST_VAL;
      end else if (ld) begin
        q_r <= d;
      end
    end

    assign cfg_q[i] = q_r;
  end

endmodule

// File: rtl/hbcfg_shadow.sv
module hbcfg_shadow
  import hbcfg_pkg::*;
#(
  parameter int unsigned SEG_COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic [SEG_COUNT-1:0] seg_en,
  output logic [SEG_COUNT-1:0] rd_int,
  output logic [SEG_COUNT-1:0] wr_int
);

  logic [SEG_COUNT-1:0] rd_int_d;
  logic [SEG_COUNT-1:0] wr_int_d;
  logic                 mode_rd_int;
  logic                 mode_wr_int;

  always_comb begin
    unique case (shd_mode_e'(mode))
      SHD_RX_WI: begin mode_rd_int = 1'b0; mode_wr_int = 1'b1; end
      SHD_RX_WX: begin mode_rd_int = 1'b0; mode_wr_int = 1'b0; end
      SHD_RI_WI: begin mode_rd_int = 1'b1; mode_wr_int = 1'b1; end
      default:   begin mode_rd_int = 1'b1; mode_wr_int = 1'b0; end
    endcase
  end

  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
    always_comb begin
      rd_int_d[s] = seg_en[s] & mode_rd_int;
      wr_int_d[s] = seg_en[s] & mode_wr_int;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_int <= '0;
      wr_int <= '0;
    end else begin
      rd_int <= rd_int_d;
      wr_int <= wr_int_d;
    end
  end

endmodule

// File: rtl/host_cfg_shadow.sv
module host_cfg_shadow
  import hbcfg_pkg::*;
#(
  parameter int unsigned FUNC_W    = 3,
  parameter int unsigned SEG_COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sys_rst,
  input  logic [FUNC_W-1:0]    cfg_func,
  input  logic [7:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  output logic [7:0]           cfg_rdata,
  output logic [SEG_COUNT-1:0] shd_rd_int,
  output logic [SEG_COUNT-1:0] shd_wr_int
);

  logic       wr_ok;
  logic [7:0] wr_byte;
  logic [7:0] cfg_q [CFG_BYTES];
  logic [1:0] mode_q;
  logic [7:0] en_byte_q;

  hbcfg_wfilter #(.FUNC_W(FUNC_W)) u_wfilter (
    .cfg_func  (cfg_func),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_wr    (cfg_wr),
    .wr_ok     (wr_ok),
    .wr_byte   (wr_byte)
  );

  hbcfg_regfile u_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_rst (sys_rst),
    .wr_ok   (wr_ok),
    .wr_addr (cfg_addr),
    .wr_byte (wr_byte),
    .cfg_q   (cfg_q)
  );

  assign mode_q    = cfg_q[OFS_MODE][MODE_LSB +: 2];
  assign en_byte_q = cfg_q[OFS_SEGEN];

  hbcfg_shadow #(.SEG_COUNT(SEG_COUNT)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_q),
    .seg_en (en_byte_q[SEGEN_LSB +: SEG_COUNT]),
    .rd_int (shd_rd_int),
    .wr_int (shd_wr_int)
  );

  always_comb begin
    if (!cfg_rd) begin
      cfg_rdata = 8'h00;
    end else if (cfg_func != '0) begin
      cfg_rdata = 8'hFF;
    end else begin
      cfg_rdata = cfg_q[cfg_addr];
    end
  end

endmodule

// File: rtl/hbcfg_checker.sv
module hbcfg_checker #(
  parameter int unsigned FUNC_W    = 3,
  parameter int unsigned SEG_COUNT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sys_rst,
  input logic [FUNC_W-1:0]    cfg_func,
  input logic [7:0]           cfg_addr,
  input logic                 cfg_rd,
  input logic [7:0]           cfg_rdata,
  input logic [SEG_COUNT-1:0] shd_rd_int,
  input logic [SEG_COUNT-1:0] shd_wr_int,
  input logic [1:0]           mode_q,
  input logic [7:0]           en_byte_q
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_func_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_func != '0) |-> cfg_rdata == 8'hFF);

  a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |-> cfg_rdata == 8'h00);

  a_r4_vendor_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_func == '0 && cfg_addr == 8'h00) |-> cfg_rdata == 8'h39);

  a_r5_cmd_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_func == '0 && cfg_addr == 8'h04) |-> ((cfg_rdata & 8'hB8) == 8'h00 && cfg_rdata[2]));

  a_r6_status_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_func == '0 && cfg_addr == 8'h07) |-> cfg_rdata == 8'h02);

  // R8 and R9: flags follow the stored bytes one edge later
  a_r9_rd_flags_lag: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> shd_rd_int == ($past(en_byte_q[4 +: SEG_COUNT]) & {SEG_COUNT{$past(mode_q[1])}}));

  a_r8_wr_flags_lag: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> shd_wr_int == ($past(en_byte_q[4 +: SEG_COUNT]) & {SEG_COUNT{~$past(mode_q[0])}}));

  a_r10_warm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (en_byte_q[7:4] == 4'h0 && en_byte_q[3:0] == $past(en_byte_q[3:0])));

  a_r11_flags_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> (shd_rd_int == '0 && shd_wr_int == '0));

endmodule

bind host_cfg_shadow hbcfg_checker #(.FUNC_W(FUNC_W), .SEG_COUNT(SEG_COUNT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sys_rst    (sys_rst),
  .cfg_func   (cfg_func),
  .cfg_addr   (cfg_addr),
  .cfg_rd     (cfg_rd),
  .cfg_rdata  (cfg_rdata),
  .shd_rd_int (shd_rd_int),
  .shd_wr_int (shd_wr_int),
  .mode_q     (mode_q),
  .en_byte_q  (en_byte_q)
);

// File: tb/host_cfg_shadow_test.sv
`timescale 1ns/1ps
module host_cfg_shadow_test;

  localparam int FW = 3;
  localparam int NS = 4;

  logic          clk;
  logic          rst_n;
  logic          sys_rst;
  logic [FW-1:0] cfg_func;
  logic [7:0]    cfg_addr;
  logic [7:0]    cfg_wdata;
  logic          cfg_wr;
  logic          cfg_rd;
  logic [7:0]    cfg_rdata;
  logic [NS-1:0] shd_rd_int;
  logic [NS-1:0] shd_wr_int;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  host_cfg_shadow #(.FUNC_W(FW), .SEG_COUNT(NS)) uut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .cfg_func(cfg_func), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .shd_rd_int(shd_rd_int), .shd_wr_int(shd_wr_int)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_default(input int a);
    case (a)
      0: return 8'h39;   1: return 8'h10;  2: return 8'h06;  3: return 8'h04;
      4: return 8'h07;   6: return 8'h80;  7: return 8'h02;  11: return 8'h06;
      80: return 8'hBC;  81: return 8'hFB; 82: return 8'hAD; 83: return 8'hFE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit exp_locked(input int a);
    return (a < 4) || (a >= 8 && a <= 12) || (a == 14) || (a >= 16 && a <= 78);
  endfunction

  function automatic logic [7:0] exp_after_write(input int a, input logic [7:0] v);
    if (exp_locked(a)) return exp_default(a);
    case (a)
      4: return (v & 8'h42) | 8'h04;
      5: return {7'd0, v[0]};
      6: return 8'h00;
      7: return 8'h02;
      default: return v;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [FW-1:0] f, input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    cfg_func = f; cfg_addr = a; cfg_wdata = v; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [FW-1:0] f, input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    cfg_func = f; cfg_addr = a; cfg_rd = 1'b1;
    #2 v = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; sys_rst = 1'b0; cfg_func = '0; cfg_addr = '0;
    cfg_wdata = '0; cfg_wr = 1'b0; cfg_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset image, R11: flags zero
    for (int a = 0; a < 256; a++) begin
      cfg_read('0, 8'(a), rv);
      check("R3 default image", rv, exp_default(a));
    end
    check("R11 flags after reset", {shd_rd_int, shd_wr_int}, 8'h00);

    // R2: read strobe low gives zero
    @(negedge clk); cfg_addr = 8'h50; cfg_rd = 1'b0; #2;
    check("R2 idle read bus", cfg_rdata, 8'h00);

    // R1: nonzero function writes ignored, reads 0xFF
    for (int a = 0; a < 256; a++) begin
      cfg_write(3'((a % 7) + 1), 8'(a), 8'hA5);
    end
    for (int a = 0; a < 256; a++) begin
      cfg_read(3'((a % 7) + 1), 8'(a), rv);
      check("R1 other function reads FF", rv, 8'hFF);
      cfg_read('0, 8'(a), rv);
      check("R1 other function write ignored", rv, exp_default(a));
    end

    // R4 R5 R6 R7: write every offset with two patterns
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 256; a++) begin
        cfg_write('0, 8'(a), 8'(a) ^ (p == 0 ? 8'h5A : 8'hFF));
      end
      for (int a = 0; a < 256; a++) begin
        cfg_read('0, 8'(a), rv);
        check("R4/R5/R6/R7 write rule", rv, exp_after_write(a, 8'(a) ^ (p == 0 ? 8'h5A : 8'hFF)));
      end
    end

    // R8 and R9: every mode and enable nibble
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 16; e++) begin
        logic [3:0] er, ew;
        cfg_write('0, 8'h53, {1'b1, 2'(m), 5'h0B});
        cfg_write('0, 8'h54, {4'(e), 4'hA});
        // one edge after store the flags must still be old? store edge passed; sample after second edge
        @(negedge clk); #1;
        case (m)
          0: begin er = 4'h0;   ew = 4'(e); end
          1: begin er = 4'h0;   ew = 4'h0;  end
          2: begin er = 4'(e);  ew = 4'(e); end
          default: begin er = 4'(e); ew = 4'h0; end
        endcase
        check("R8 segment flags", {shd_rd_int, shd_wr_int}, {er, ew});
      end
    end

    // R9: latency, flags unchanged on the store edge, updated on the next
    cfg_write('0, 8'h53, 8'h40);          // mode 10
    cfg_write('0, 8'h54, 8'h00);
    @(negedge clk);
    @(negedge clk);
    cfg_func = '0; cfg_addr = 8'h54; cfg_wdata = 8'h30; cfg_wr = 1'b1;
    @(posedge clk); #1;                   // byte stored here
    cfg_wr = 1'b0;
    check("R9 flags hold on store edge", {shd_rd_int, shd_wr_int}, 8'h00);
    @(posedge clk); #1;
    check("R9 flags update next edge", {shd_rd_int, shd_wr_int}, 8'h33);

    // R10: warm reset clears enables, keeps low nibble, drops colliding write
    cfg_write('0, 8'h60, 8'h77);
    cfg_write('0, 8'h54, 8'hF6);
    @(negedge clk);
    sys_rst = 1'b1; cfg_func = '0; cfg_addr = 8'h60; cfg_wdata = 8'h11; cfg_wr = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0; cfg_wr = 1'b0;
    cfg_read('0, 8'h54, rv);
    check("R10 enable byte after warm reset", rv, 8'h06);
    cfg_read('0, 8'h60, rv);
    check("R10 colliding write dropped", rv, 8'h77);
    @(negedge clk);
    check("R10 flags off", {shd_rd_int, shd_wr_int}, 8'h00);

    // R11: asynchronous reset mid-run
    cfg_write('0, 8'h50, 8'h12);
    cfg_write('0, 8'h54, 8'hF0);
    @(negedge clk); @(negedge clk);
    check("R11 flags before reset", {shd_rd_int, shd_wr_int}, 8'hFF);
    #1 rst_n = 1'b0;
    #1;
    check("R11 flags cleared asynchronously", {shd_rd_int, shd_wr_int}, 8'h00);
    cfg_rd = 1'b1; cfg_func = '0; cfg_addr = 8'h50; #1;
    check("R11 image restored", cfg_rdata, 8'hBC);
    cfg_rd = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_read('0, 8'h54, rv);
    check("R11 enable byte restored", rv, 8'h00);

    finish_run();
  end

endmodule